// File: doc/BRIEF.md
# Four-Channel Memory-Mapped Interval Timer

This peripheral holds four identical 32-bit up-counters behind one small register space. Each channel advances only on a cycle in which its own tick-enable input is high. One system clock can therefore serve channels that run at very different rates, for example 32768 Hz, 1 kHz and 1 MHz enables. Software steers a channel through command addresses (reset, start, stop), where the write data does not matter. A channel can run once or repeat. Its period is set by a terminal-count register. It raises a pending flag, which becomes an interrupt when enabled and is cleared by an acknowledge write.

Software typically programs a channel with this sequence: interrupt off, stop, reset, terminal count, mode, interrupt on, start. The channel then fires after exactly the programmed number of ticks. A channel left in repeat mode with terminal count 0xFFFFFFFF serves as a free-running timestamp. A shared clock-request bit, readable back, drives a separate output.

Top module: `mmio_interval_timer`

## Requirements
- R1: Channel k occupies byte addresses 0x40*k to 0x40*k+0x3F. Inside a window, offset 0x10 reads the status word, 0x14 the current count and 0x18 the terminal count. Offset 0x18 is also writable. A read of any other channel offset (the write-only ones at 0x00, 0x04, 0x08, 0x0C, 0x1C, 0x20, or an unused one) returns 0, as does a read of any unused address above the windows.
- R2: A write to offset 0x00 resets the channel, a write to 0x04 starts it and a write to 0x08 stops it, whatever the data. Reset clears the count, the pending flag and the running flag, and keeps the terminal count, the mode and the interrupt enable.
- R3: A running channel adds one to its count on each clock edge where its own tick input is high. A stopped channel holds its count, and the tick inputs of other channels have no effect on it.
- R4: With terminal count T, the tick that would make the count equal T instead returns it to 0 and sets the pending flag. The period is therefore T ticks, and T = 0 gives a period of 2^32. In repeat mode (mode bit 0 = 0) the channel keeps running. With T = 0xFFFFFFFF it counts freely.
- R5: In one-shot mode (offset 0x0C, bit 0 = 1), the terminal tick also stops the channel.
- R6: The status word has these fields: bit 7 = pending, bit 6 = interrupt enabled, bit 5 = one-shot, bit 4 = running, bits [3:0] = 2 while running and 1 while stopped. Bits [31:8] are 0.
- R7: Offset 0x1C bit 0 sets the interrupt enable. irq[k] is high exactly when channel k has both its pending flag and its interrupt enable set.
- R8: A write to offset 0x20 with bit 7 set clears the pending flag, and a write with bit 7 clear changes nothing. A terminal tick in the same cycle as the acknowledge leaves the flag set.
- R9: Byte address 0x100 holds the clock-request bit (bit 0). It reads back with the other bits 0 and drives clock_req.
- R10: After the programming sequence (interrupt off, stop, reset, terminal count N, one-shot mode, interrupt on, start), the pending flag and irq rise on the N-th tick and not before.
- R11: Channels are independent. A write to one channel's window changes no other channel.
- R12: After rst every channel reads status 0x01, count 0 and terminal count 0, irq is all zero and clock_req is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Byte address for reads and writes |
| bus_wen | input | 1 | Write strobe, one register write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_en | input | 4 | Per-channel count enable |
| irq | output | 4 | Per-channel interrupt |
| clock_req | output | 1 | Clock-request control bit |

## Verification
The hardest situation to reach from the ports is a collision: a terminal tick in the same cycle as a bus command to that channel. This covers an acknowledge that must lose to a new fire, a reset that must win over it, and a start that must win over the one-shot stop. A directed case lines up a terminal tick under an acknowledge. A long random phase then uses small terminal counts and dense random ticks while it writes random commands every few cycles, so these overlaps happen many times. A bench model written from the requirements judges every read and every irq level.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam int DATA_W = 32;
    localparam int WIN_W  = 6;      // 64-byte channel window
    localparam logic [DATA_W-1:0] ONE = 1;

    // channel-relative offsets
    localparam logic [WIN_W-1:0] OFF_RST    = 6'h00;
    localparam logic [WIN_W-1:0] OFF_START  = 6'h04;
    localparam logic [WIN_W-1:0] OFF_STOP   = 6'h08;
    localparam logic [WIN_W-1:0] OFF_MODE   = 6'h0C;
    localparam logic [WIN_W-1:0] OFF_STATUS = 6'h10;
    localparam logic [WIN_W-1:0] OFF_COUNT  = 6'h14;
    localparam logic [WIN_W-1:0] OFF_TERM   = 6'h18;
    localparam logic [WIN_W-1:0] OFF_IEN    = 6'h1C;
    localparam logic [WIN_W-1:0] OFF_ACK    = 6'h20;

    localparam logic [3:0] CODE_IDLE = 4'd1;
    localparam logic [3:0] CODE_RUN  = 4'd2;

    typedef struct packed {
        logic rst;
        logic start;
        logic stop;
        logic mode_wr;
        logic term_wr;
        logic ien_wr;
        logic ack;
    } chan_cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] term;
        logic              oneshot;
        logic              ien;
        logic              pend;
        logic              run;
    } chan_state_t;

    function automatic logic [DATA_W-1:0] status_word(input chan_state_t s);
        return {{(DATA_W-8){1'b0}}, s.pend, s.ien, s.oneshot, s.run,
                (s.run ? CODE_RUN : CODE_IDLE)};
    endfunction
endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
    import itmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int SEL_W  = $clog2(NUM_CH),
    localparam int ADDR_W = SEL_W + WIN_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wen,
    input  logic              ack_bit,
    output chan_cmd_t         cmd [NUM_CH],
    output logic              creq_wr
);
    localparam logic [ADDR_W-1:0] CREQ_ADDR = ADDR_W'(NUM_CH * (1 << WIN_W));

    logic             in_win;
    logic [SEL_W-1:0] sel;
    logic [WIN_W-1:0] off;

    assign in_win  = !addr[ADDR_W-1];
    assign sel     = addr[WIN_W +: SEL_W];
    assign off     = addr[WIN_W-1:0];
    assign creq_wr = wen && (addr == CREQ_ADDR);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_cmd
        logic hit;
        assign hit = wen && in_win && (sel == SEL_W'(k));
        always_comb begin
            cmd[k]         = '0;
            cmd[k].rst     = hit && (off == OFF_RST);
            cmd[k].start   = hit && (off == OFF_START);
            cmd[k].stop    = hit && (off == OFF_STOP);
            cmd[k].mode_wr = hit && (off == OFF_MODE);
            cmd[k].term_wr = hit && (off == OFF_TERM);
            cmd[k].ien_wr  = hit && (off == OFF_IEN);
            cmd[k].ack     = hit && (off == OFF_ACK) && ack_bit;
        end
    end
endmodule

// File: rtl/itmr_channel.sv
module itmr_channel
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_cmd_t         cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output chan_state_t       st,
    output logic              irq
);
    chan_state_t       nx;
    logic              fire;
    logic [DATA_W-1:0] inc;

    assign inc = st.cnt + ONE;

    always_comb begin
        nx   = st;
        fire = 1'b0;
        if (tick && st.run) begin
            if (inc == st.term) begin
                fire    = 1'b1;
                nx.cnt  = '0;
                nx.pend = 1'b1;
                if (st.oneshot) nx.run = 1'b0;
            end else begin
                nx.cnt = inc;
            end
        end
        if (cmd.ack && !fire) nx.pend    = 1'b0;
        if (cmd.start)        nx.run     = 1'b1;
        if (cmd.stop)         nx.run     = 1'b0;
        if (cmd.mode_wr)      nx.oneshot = wdata[0];
        if (cmd.term_wr)      nx.term    = wdata;
        if (cmd.ien_wr)       nx.ien     = wdata[0];
        if (cmd.rst) begin
            nx.cnt  = '0;
            nx.pend = 1'b0;
            nx.run  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nx;
    end

    assign irq = st.pend && st.ien;

    // R3
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!st.run && !cmd.rst) |=> $stable(st.cnt));
    // R4
    pend_from_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st.pend) |-> $past(tick && st.run));
    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && st.oneshot && !cmd.start) |=> !st.run);
    // R2
    strobe_reset_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.rst |=> (st.cnt == '0 && !st.pend && !st.run));
    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.ack && !fire) |=> !st.pend);
endmodule

// File: rtl/mmio_interval_timer.sv
module mmio_interval_timer
    import itmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int SEL_W  = $clog2(NUM_CH),
    localparam int ADDR_W = SEL_W + WIN_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] tick_en,
    output logic [NUM_CH-1:0] irq,
    output logic              clock_req
);
    localparam logic [ADDR_W-1:0] CREQ_ADDR = ADDR_W'(NUM_CH * (1 << WIN_W));

    chan_cmd_t   cmd [NUM_CH];
    chan_state_t st  [NUM_CH];
    logic        creq_wr;
    logic        creq_q;

    itmr_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr    (bus_addr),
        .wen     (bus_wen),
        .ack_bit (bus_wdata[7]),
        .cmd     (cmd),
        .creq_wr (creq_wr)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        itmr_channel u_ch (
            .clk   (clk),
            .rst   (rst),
            .cmd   (cmd[k]),
            .wdata (bus_wdata),
            .tick  (tick_en[k]),
            .st    (st[k]),
            .irq   (irq[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)          creq_q <= 1'b0;
        else if (creq_wr) creq_q <= bus_wdata[0];
    end
    assign clock_req = creq_q;

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr[ADDR_W-1]) begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (bus_addr[WIN_W +: SEL_W] == SEL_W'(k)) begin
                    case (bus_addr[WIN_W-1:0])
                        OFF_STATUS: bus_rdata = status_word(st[k]);
                        OFF_COUNT:  bus_rdata = st[k].cnt;
                        OFF_TERM:   bus_rdata = st[k].term;
                        default:    bus_rdata = '0;
                    endcase
                end
            end
        end else if (bus_addr == CREQ_ADDR) begin
            bus_rdata = {{(DATA_W-1){1'b0}}, creq_q};
        end
    end

    // R9
    creq_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == CREQ_ADDR) |=> (clock_req == $past(bus_wdata[0])));
    // R11
    creq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wen && bus_addr == CREQ_ADDR) |=> $stable(clock_req));
endmodule

// File: tb/mmio_interval_timer_test.sv
module mmio_interval_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst;
    logic [8:0]  bus_addr;
    logic        bus_wen;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_en;
    logic [3:0]  irq;
    logic        clock_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [31:0] m_cnt [4];
    logic [31:0] m_tc  [4];
    logic        m_os [4], m_ie [4], m_pd [4], m_en [4];
    logic        m_cr;

    mmio_interval_timer uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .irq(irq), .clock_req(clock_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, act=%0d exp<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] exp_status(input int c);
        return {24'h0, m_pd[c], m_ie[c], m_os[c], m_en[c], (m_en[c] ? 4'd2 : 4'd1)};
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] v;
        for (int c = 0; c < 4; c++) v[c] = m_pd[c] & m_ie[c];
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input logic [8:0] a);
        int c;
        if (a == 9'h100) return {31'h0, m_cr};
        if (a[8]) return 32'h0;
        c = int'(a[7:6]);
        case (a[5:0])
            6'h10:   return exp_status(c);
            6'h14:   return m_cnt[c];
            6'h18:   return m_tc[c];
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_cnt[c] = 0; m_tc[c] = 0; m_os[c] = 0; m_ie[c] = 0; m_pd[c] = 0; m_en[c] = 0;
        end
        m_cr = 0;
    endtask

    task automatic model_apply(input logic w, input logic [8:0] a,
                               input logic [31:0] d, input logic [3:0] t);
        logic fired [4];
        for (int c = 0; c < 4; c++) begin
            fired[c] = 0;
            if (t[c] && m_en[c]) begin
                if (m_cnt[c] + 32'd1 == m_tc[c]) begin
                    m_cnt[c] = 0; m_pd[c] = 1; fired[c] = 1;
                    if (m_os[c]) m_en[c] = 0;
                end else m_cnt[c] = m_cnt[c] + 32'd1;
            end
        end
        if (w) begin
            if (a == 9'h100) m_cr = d[0];
            else if (!a[8]) begin
                int c;
                c = int'(a[7:6]);
                case (a[5:0])
                    6'h00: begin m_cnt[c] = 0; m_pd[c] = 0; m_en[c] = 0; end
                    6'h04: m_en[c] = 1;
                    6'h08: m_en[c] = 0;
                    6'h0C: m_os[c] = d[0];
                    6'h18: m_tc[c] = d;
                    6'h1C: m_ie[c] = d[0];
                    6'h20: if (d[7] && !fired[c]) m_pd[c] = 0;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [8:0] a,
                        input logic [31:0] d, input logic [3:0] t);
        bus_wen = w; bus_addr = a; bus_wdata = d; tick_en = t;
        model_apply(w, a, d, t);
        @(posedge clk);
        @(negedge clk);
        bus_wen = 0; tick_en = 0;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        step(1'b1, a, d, 4'b0);
    endtask

    task automatic rd(input string tag, input logic [8:0] a, input logic [31:0] exp);
        bus_wen = 0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        void'($urandom(32'h5eed_0017));
        bus_wen = 0; bus_addr = 0; bus_wdata = 0; tick_en = 0;
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R12 reset state
        for (int c = 0; c < 4; c++) begin
            rd("R12 status", 9'(c*64 + 16), 32'h1);
            rd("R12 count",  9'(c*64 + 20), 32'h0);
            rd("R12 term",   9'(c*64 + 24), 32'h0);
        end
        chk("R12 irq", {28'h0, irq}, 32'h0);
        chk("R12 clock_req", {31'h0, clock_req}, 32'h0);

        // R9 clock request
        wr(9'h100, 32'h1);
        rd("R9 readback", 9'h100, 32'h1);
        chk("R9 clock_req", {31'h0, clock_req}, 32'h1);
        wr(9'h100, 32'hFFFF_FFFE);
        rd("R9 clear", 9'h100, 32'h0);

        // R1 map and zero reads
        wr(9'h098, 32'h0000_55AA);
        rd("R1 term ch2", 9'h098, 32'h0000_55AA);
        rd("R11 term ch1 untouched", 9'h058, 32'h0);
        rd("R1 wo mode", 9'h08C, 32'h0);
        rd("R1 wo ien", 9'h09C, 32'h0);
        rd("R1 wo ack", 9'h0A0, 32'h0);
        rd("R1 wo rst", 9'h080, 32'h0);
        rd("R1 unused", 9'h03C, 32'h0);
        rd("R1 above", 9'h104, 32'h0);

        // R10 programming sequence on ch1, N = 5, one-shot
        wr(9'h05C, 32'h0);
        wr(9'h048, 32'h0);
        wr(9'h040, 32'h0);
        wr(9'h058, 32'd5);
        wr(9'h04C, 32'h1);
        wr(9'h05C, 32'h1);
        wr(9'h044, 32'hDEAD_BEEF);   // R2 data ignored
        rd("R6 running status", 9'h050, 32'h72);
        repeat (4) step(1'b0, 9'h0, 32'h0, 4'b0010);
        rd("R10 count before fire", 9'h054, 32'd4);
        chk("R10 no irq before N", {28'h0, irq}, 32'h0);
        step(1'b0, 9'h0, 32'h0, 4'b0010);
        chk("R10 irq at N", {28'h0, irq}, 32'h2);
        rd("R5 oneshot status", 9'h050, 32'hE1);
        rd("R5 count zero", 9'h054, 32'h0);
        step(1'b0, 9'h0, 32'h0, 4'b0010);
        rd("R5 stays stopped", 9'h054, 32'h0);

        // R8 acknowledge
        wr(9'h060, 32'h7F);
        chk("R8 ack without bit7", {28'h0, irq}, 32'h2);
        wr(9'h060, 32'h80);
        chk("R8 ack bit7", {28'h0, irq}, 32'h0);
        rd("R8 status after ack", 9'h050, 32'h61);

        // R2 reset keeps settings
        wr(9'h044, 32'h0);
        step(1'b0, 9'h0, 32'h0, 4'b0010);
        wr(9'h040, 32'hFFFF_FFFF);
        rd("R2 reset status", 9'h050, 32'h61);
        rd("R2 reset count", 9'h054, 32'h0);
        rd("R2 term kept", 9'h058, 32'd5);

        // R4 continuous on ch0, T = 3, irq disabled
        wr(9'h018, 32'd3);
        wr(9'h00C, 32'h0);
        wr(9'h004, 32'h0);
        repeat (3) step(1'b0, 9'h0, 32'h0, 4'b0001);
        rd("R4 wrap status", 9'h010, 32'h92);
        rd("R4 wrap count", 9'h014, 32'h0);
        chk("R7 irq masked", {28'h0, irq}, 32'h0);
        wr(9'h01C, 32'h1);
        chk("R7 irq unmasked", {28'h0, irq}, 32'h1);

        // R3 other ticks do not move ch0; stopped channel holds
        step(1'b0, 9'h0, 32'h0, 4'b0001);
        repeat (3) step(1'b0, 9'h0, 32'h0, 4'b1110);
        rd("R3 foreign ticks", 9'h014, 32'h1);
        rd("R3 stopped ch1", 9'h054, 32'h0);

        // R8 collision: ack with terminal tick -> stays pending
        step(1'b0, 9'h0, 32'h0, 4'b0001);
        rd("R8 pre collision count", 9'h014, 32'h2);
        step(1'b1, 9'h020, 32'h80, 4'b0001);
        chk("R8 fire beats ack", {28'h0, irq}, 32'h1);
        rd("R8 collision count", 9'h014, 32'h0);

        // R4 free-running timestamp on ch3
        wr(9'h0D8, 32'hFFFF_FFFF);
        wr(9'h0C4, 32'h0);
        repeat (10) step(1'b0, 9'h0, 32'h0, 4'b1000);
        rd("R4 free-run count", 9'h0D4, 32'd10);

        // random phase (R3 R4 R5 R7 R8 R11)
        for (int i = 0; i < 4000; i++) begin
            logic        w;
            logic [8:0]  a;
            logic [31:0] d;
            logic [5:0]  offs [9];
            offs = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h18, 6'h1C, 6'h20, 6'h04, 6'h18};
            w = ($urandom % 4) == 0;
            a = {1'b0, 2'($urandom % 4), offs[$urandom % 9]};
            d = $urandom;
            if (a[5:0] == 6'h18) d = $urandom % 12;
            if (($urandom % 50) == 0) a = 9'h100;
            step(w, a, d, 4'($urandom));
            begin
                logic [5:0] ro [4];
                logic [8:0] ra;
                ro = '{6'h10, 6'h14, 6'h18, 6'h20};
                ra = {1'b0, 2'($urandom % 4), ro[$urandom % 4]};
                rd("R4 random read", ra, exp_read(ra));
            end
            chk("R7 random irq", {28'h0, irq}, {28'h0, exp_irq()});
            chk("R9 random clock_req", {31'h0, clock_req}, {31'h0, m_cr});
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule